// File: doc/BRIEF.md
# Auto-MDIX Link Sequencer

This block brings a copper Ethernet port's link up after reset without knowing which way the cable is wired. It begins with straight-through (MDI) pairing. At a fixed interval it reads the PHY's basic status register through an external MDIO master. Each time that read finds no link, it flips the crossover select. It stops with a fail flag once a set number of polls has gone by without success.

When link is found, the block reads the status register a second time. It goes on only if negotiation or parallel detection has completed. It then reads the PHY's vendor status register to learn speed and duplex. If both ends can negotiate and both advertise pause, a chain of further reads finds the pause result. The outcome is published as a four-bit port status word. The MDIO master is driven through a simple hold-until-done read request, one read at a time.

Top module: `mdix_link_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `mdix_sel` is 0 (MDI), `link_fail` is 0, `port_status` is 0 and `rd_req` is 0.
- R2: The first link poll request rises exactly WAIT_CYCLES cycles after reset release. After every failed poll completes, the request stays low for exactly WAIT_CYCLES cycles before the next poll.
- R3: A link poll reads register 1. Link is up when bit 2 of the returned data is 1, and no other bit matters. When bit 2 is 0, `mdix_sel` inverts in the cycle after the done handshake.
- R4: When the MAX_POLLS-th poll fails, `link_fail` rises in the same cycle as that poll's select inversion. No further requests are issued, and the flag stays set until reset.
- R5: After link is found, register 1 is read again. If bit 5 of that read is 0, the sequence ends with `port_status` left at 0 and no further reads.
- R6: Speed and duplex come from bits 4:2 of register 31. Code 1 gives 10 Mb/s half duplex, 5 gives 10 full, 2 gives 100 half and 6 gives 100 full.
- R7: Any other code in register 31 bits 4:2 leaves the speed and duplex bits 0, and the status is still written with link set.
- R8: Pause detection runs as a chain. It proceeds only if bit 3 of the second register-1 read is 1, then register 6 bit 0 is 1, then register 4 bit 10 is 1. Pause is then register 5 bit 10. Any step that fails ends the chain with pause 0 and no further reads.
- R9: `port_status` is bit 3 link up, bit 2 pause, bit 1 full duplex, bit 0 100 Mb/s. It is written once, in the cycle after the last read's done, and link up is always 1 when it is written.
- R10: `rd_req` stays high with `rd_reg` stable until `rd_done`. Only one read is outstanding at a time, and `rd_phy` always equals PHY_ADDR.
- R11: Once link is found, `mdix_sel` keeps the value it had on the successful poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdix_sel | output | 1 | Pair select: 0 straight (MDI), 1 crossed (MDIX) |
| rd_req | output | 1 | MDIO read request, held until done |
| rd_phy | output | 5 | PHY address of the request |
| rd_reg | output | 5 | PHY register address of the request |
| rd_done | input | 1 | One-cycle completion of the pending read |
| rd_data | input | 16 | Read data, valid with rd_done |
| port_status | output | 4 | {link, pause, full duplex, 100 Mb/s} |
| link_fail | output | 1 | No link after MAX_POLLS polls |

## Verification
The select inversion and the fail flag can change on the same edge: the last permitted poll that finds no link both flips the pairing and ends the search. The bench provokes this with a PHY model that never reports link. Its per-cycle reference model expects `mdix_sel` and `link_fail` to change together at the same clock and the request line to stay quiet afterwards. Other runs vary the response latency so that the done handshake lands at different distances from the request.

// File: rtl/mdix_seq_pkg.sv
// Package: shared state encoding, status layout and PHY register map
// for the auto-MDIX link sequencer.
package mdix_seq_pkg;

    typedef enum logic [3:0] {
        ST_WAIT,
        ST_POLL,
        ST_CONFIRM,
        ST_MODE,
        ST_EXPAN,
        ST_ADVERT,
        ST_PARTNER,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        logic link;
        logic pause;
        logic full;
        logic fast;
    } port_stat_t;

    localparam logic [4:0] REG_BASIC   = 5'd1;
    localparam logic [4:0] REG_ADVERT  = 5'd4;
    localparam logic [4:0] REG_PARTNER = 5'd5;
    localparam logic [4:0] REG_EXPAN   = 5'd6;
    localparam logic [4:0] REG_VSTAT   = 5'd31;

    localparam int BIT_LINK     = 2;
    localparam int BIT_ANEG_OK  = 3;
    localparam int BIT_COMPLETE = 5;
    localparam int BIT_LP_ANEG  = 0;
    localparam int BIT_PAUSE    = 10;

endpackage

// File: rtl/mdix_interval_timer.sv
// Interval timer: counts cycles while 'run' is high and flags the last
// cycle of a WAIT_CYCLES-long interval. Assumes run drops once expired.
module mdix_interval_timer #(
    parameter int WAIT_CYCLES = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles of the current interval, cleared whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);

    // R2: a running interval never counts past its end.
    p_count_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= LAST));

    // R2: expiry is followed by the owner leaving the wait.
    p_expire_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);

endmodule

// File: rtl/mdix_mode_decode.sv
// Speed/duplex decoder: maps the 3-bit PHY mode code to speed and duplex
// flags. Unlisted codes give 10 Mb/s half duplex (both flags low).
module mdix_mode_decode (
    input  logic [2:0] code,
    output logic       fast,
    output logic       full
);
    // Translate the mode code into the two status flags.
    always_comb begin
        fast = 1'b0;
        full = 1'b0;
        case (code)
            3'd1:    begin fast = 1'b0; full = 1'b0; end
            3'd5:    begin fast = 1'b0; full = 1'b1; end
            3'd2:    begin fast = 1'b1; full = 1'b0; end
            3'd6:    begin fast = 1'b1; full = 1'b1; end
            default: begin fast = 1'b0; full = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mdix_link_seq.sv
// Auto-MDIX link sequencer (top). Polls PHY register 1 once per interval,
// inverting the pair select after each failed poll, then reads speed,
// duplex and pause results and writes the port status word once.
// Assumes the MDIO master answers each held request with one rd_done pulse.
module mdix_link_seq
    import mdix_seq_pkg::*;
#(
    parameter int         WAIT_CYCLES = 200_000_000,
    parameter int         MAX_POLLS   = 100,
    parameter logic [4:0] PHY_ADDR    = 5'd6
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        mdix_sel,
    output logic        rd_req,
    output logic [4:0]  rd_phy,
    output logic [4:0]  rd_reg,
    input  logic        rd_done,
    input  logic [15:0] rd_data,
    output logic [3:0]  port_status,
    output logic        link_fail
);
    localparam int TW = $clog2(MAX_POLLS + 1);
    localparam logic [TW-1:0] LAST_TRY = TW'(MAX_POLLS - 1);

    seq_state_e    state_q;
    port_stat_t    stat_q;
    logic [TW-1:0] tries_q;
    logic          sel_q, fail_q, aneg_q, fast_q, full_q;
    logic          wait_over, dec_fast, dec_full;
    logic          unused_data;

    assign unused_data = ^{rd_data[15:11], rd_data[9:6], rd_data[1]};

    mdix_interval_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_WAIT),
        .expired (wait_over)
    );

    mdix_mode_decode u_decode (
        .code (rd_data[4:2]),
        .fast (dec_fast),
        .full (dec_full)
    );

    // Pick the register address that belongs to the current read state.
    always_comb begin
        case (state_q)
            ST_POLL, ST_CONFIRM: rd_reg = REG_BASIC;
            ST_MODE:             rd_reg = REG_VSTAT;
            ST_EXPAN:            rd_reg = REG_EXPAN;
            ST_ADVERT:           rd_reg = REG_ADVERT;
            ST_PARTNER:          rd_reg = REG_PARTNER;
            default:             rd_reg = 5'd0;
        endcase
    end

    assign rd_req      = (state_q inside {ST_POLL, ST_CONFIRM, ST_MODE,
                                          ST_EXPAN, ST_ADVERT, ST_PARTNER});
    assign rd_phy      = PHY_ADDR;
    assign mdix_sel    = sel_q;
    assign link_fail   = fail_q;
    assign port_status = stat_q;

    // Sequence the polls, the pairing swaps and the status reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            stat_q  <= '0;
            tries_q <= '0;
            sel_q   <= 1'b0;
            fail_q  <= 1'b0;
            aneg_q  <= 1'b0;
            fast_q  <= 1'b0;
            full_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_WAIT: if (wait_over) state_q <= ST_POLL;
                ST_POLL: if (rd_done) begin
                    if (rd_data[BIT_LINK]) begin
                        state_q <= ST_CONFIRM;
                    end else begin
                        sel_q <= ~sel_q;
                        if (tries_q == LAST_TRY) begin
                            fail_q  <= 1'b1;
                            state_q <= ST_FAIL;
                        end else begin
                            tries_q <= tries_q + 1'b1;
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_CONFIRM: if (rd_done) begin
                    if (rd_data[BIT_COMPLETE]) begin
                        aneg_q  <= rd_data[BIT_ANEG_OK];
                        state_q <= ST_MODE;
                    end else begin
                        state_q <= ST_DONE;
                    end
                end
                ST_MODE: if (rd_done) begin
                    fast_q <= dec_fast;
                    full_q <= dec_full;
                    if (aneg_q) begin
                        state_q <= ST_EXPAN;
                    end else begin
                        stat_q  <= {1'b1, 1'b0, dec_full, dec_fast};
                        state_q <= ST_DONE;
                    end
                end
                ST_EXPAN: if (rd_done) begin
                    if (rd_data[BIT_LP_ANEG]) begin
                        state_q <= ST_ADVERT;
                    end else begin
                        stat_q  <= {1'b1, 1'b0, full_q, fast_q};
                        state_q <= ST_DONE;
                    end
                end
                ST_ADVERT: if (rd_done) begin
                    if (rd_data[BIT_PAUSE]) begin
                        state_q <= ST_PARTNER;
                    end else begin
                        stat_q  <= {1'b1, 1'b0, full_q, fast_q};
                        state_q <= ST_DONE;
                    end
                end
                ST_PARTNER: if (rd_done) begin
                    stat_q  <= {1'b1, rd_data[BIT_PAUSE], full_q, fast_q};
                    state_q <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    // R1: the first cycle after reset starts straight pairing, all clear.
    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!mdix_sel && !link_fail && port_status == 4'd0 && !rd_req));

    // R3: a failed poll flips the pairing on the next cycle.
    p_swap_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL && rd_done && !rd_data[BIT_LINK]) |=> (mdix_sel != $past(mdix_sel)));

    // R4: the fail flag is sticky and silences the request line.
    p_fail_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail |=> (link_fail && !rd_req));

    // R9: a written status always carries link up.
    p_link_marked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (port_status != 4'd0) |-> port_status[3]);

    // R10: a request holds with a stable address until done.
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_done) |=> (rd_req && $stable(rd_reg)));

    // R11: pairing never moves once link has been found.
    p_sel_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_CONFIRM, ST_MODE, ST_EXPAN, ST_ADVERT, ST_PARTNER, ST_DONE})
        |=> $stable(mdix_sel));

endmodule

// File: tb/test_mdix_link_seq.sv
`timescale 1ns/1ps
module test_mdix_link_seq;
    localparam int W = 20;
    localparam int M = 6;
    localparam logic [4:0] PHY = 5'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdix_sel, rd_req, link_fail;
    logic [4:0]  rd_phy, rd_reg;
    logic        rd_done = 1'b0;
    logic [15:0] rd_data = 16'h0;
    logic [3:0]  port_status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // PHY model settings
    int          link_at, resp_lat, lat_cnt, poll_n;
    bit          found;
    logic [15:0] conf_v, mode_v, r6_v, r4_v, r5_v;

    // reference model state
    int          m_state, m_cnt, ph, polls;
    bit          exp_sel, exp_fail, abil, e_fast, e_full;
    logic [3:0]  exp_stat;
    logic [4:0]  exp_reg;

    always #5 clk = ~clk;

    mdix_link_seq #(.WAIT_CYCLES(W), .MAX_POLLS(M), .PHY_ADDR(PHY)) i_mdix_link_seq (
        .clk(clk), .rst_n(rst_n), .mdix_sel(mdix_sel), .rd_req(rd_req),
        .rd_phy(rd_phy), .rd_reg(rd_reg), .rd_done(rd_done), .rd_data(rd_data),
        .port_status(port_status), .link_fail(link_fail));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // PHY/MDIO responder: answers each request after resp_lat idle cycles.
    always @(negedge clk) begin
        if (!rst_n || rd_done) begin
            rd_done = 1'b0;
            lat_cnt = resp_lat;
        end else if (rd_req) begin
            if (lat_cnt == 0) begin
                rd_done = 1'b1;
                case (rd_reg)
                    5'd1: begin
                        if (!found) begin
                            poll_n++;
                            if (poll_n == link_at) begin found = 1; rd_data = 16'h0004; end
                            else rd_data = 16'hFFFB;
                        end else rd_data = conf_v;
                    end
                    5'd31: rd_data = mode_v;
                    5'd6:  rd_data = r6_v;
                    5'd4:  rd_data = r4_v;
                    5'd5:  rd_data = r5_v;
                    default: rd_data = 16'hDEAD;
                endcase
            end else lat_cnt--;
        end
    end

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; ph = 0; polls = 0;
            exp_sel = 0; exp_fail = 0; exp_stat = 4'd0; exp_reg = 5'd1; abil = 0;
        end else if (m_state == 0) begin
            m_cnt++;
            if (m_cnt == W) begin m_state = 1; exp_reg = 5'd1; end
        end else if (m_state == 1 && rd_done) begin
            case (ph)
                0: begin
                    polls++;
                    if (rd_data[2]) ph = 1;
                    else begin
                        exp_sel = !exp_sel;
                        if (polls == M) begin exp_fail = 1; m_state = 2; end
                        else begin m_state = 0; m_cnt = 0; end
                    end
                end
                1: if (!rd_data[5]) m_state = 2;
                   else begin abil = rd_data[3]; ph = 2; exp_reg = 5'd31; end
                2: begin
                    e_fast = (rd_data[4:2] == 3'd2) || (rd_data[4:2] == 3'd6);
                    e_full = (rd_data[4:2] == 3'd5) || (rd_data[4:2] == 3'd6);
                    if (abil) begin ph = 3; exp_reg = 5'd6; end
                    else begin exp_stat = {1'b1, 1'b0, e_full, e_fast}; m_state = 2; end
                end
                3: if (rd_data[0]) begin ph = 4; exp_reg = 5'd4; end
                   else begin exp_stat = {1'b1, 1'b0, e_full, e_fast}; m_state = 2; end
                4: if (rd_data[10]) begin ph = 5; exp_reg = 5'd5; end
                   else begin exp_stat = {1'b1, 1'b0, e_full, e_fast}; m_state = 2; end
                default: begin exp_stat = {1'b1, rd_data[10], e_full, e_fast}; m_state = 2; end
            endcase
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(mdix_sel == exp_sel, "R3/R11 select", mdix_sel, exp_sel);
            check(link_fail == exp_fail, "R4 fail flag", link_fail, exp_fail);
            check(port_status == exp_stat, "R9 status", port_status, exp_stat);
            check(rd_req == (m_state == 1), "R2 request timing", rd_req, m_state == 1);
            if (rd_req) begin
                check(rd_reg == exp_reg, "R10 register order", rd_reg, exp_reg);
                check(rd_phy == PHY, "R10 phy address", rd_phy, PHY);
            end
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_case(input int la, input int lat, input logic [15:0] conf,
                            input logic [2:0] code, input logic [15:0] r6,
                            input logic [15:0] r4, input logic [15:0] r5,
                            input logic [3:0] e_st, input bit e_s, input bit e_f,
                            input string tag);
        rst_n = 0;
        link_at = la; resp_lat = lat; conf_v = conf;
        mode_v = 16'hFFE3 | {11'd0, code, 2'b00};
        r6_v = r6; r4_v = r4; r5_v = r5; found = 0; poll_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!rd_req && port_status == 4'd0 && !link_fail, "R1 after release", rd_req, 0);
        for (int n = 0; n < 3000 && m_state != 2; n++) @(negedge clk);
        repeat (3 * W) @(negedge clk);
        check(port_status == e_st, {tag, " final status"}, port_status, e_st);
        check(mdix_sel == e_s, {tag, " final select"}, mdix_sel, e_s);
        check(link_fail == e_f, {tag, " final fail"}, link_fail, e_f);
    endtask

    initial begin
        resp_lat = 0;
        repeat (2) @(negedge clk);
        check(!mdix_sel && !link_fail && port_status == 4'd0 && !rd_req, "R1 in reset", mdix_sel, 0);
        // R6 R8: 100 full, whole pause chain passes, link on poll 3
        run_case(3, 1, 16'h0028, 3'd6, 16'h0001, 16'h0400, 16'h0400, 4'b1111, 1'b0, 1'b0, "R6/R8 full chain");
        // R6: 10 half, no negotiation ability, slow responder
        run_case(1, 2, 16'h0020, 3'd1, 16'h0, 16'h0, 16'h0, 4'b1000, 1'b0, 1'b0, "R6 10 half");
        // R11 R8: link on poll 2 in crossed pairing, partner cannot negotiate
        run_case(2, 0, 16'h0028, 3'd5, 16'h0000, 16'h0400, 16'h0400, 4'b1010, 1'b1, 1'b0, "R11/R8 no partner aneg");
        // R8: pause not advertised locally
        run_case(1, 1, 16'h0028, 3'd2, 16'h0001, 16'h0000, 16'h0400, 4'b1001, 1'b0, 1'b0, "R8 no local pause");
        // R8: partner does not advertise pause
        run_case(1, 0, 16'h0028, 3'd6, 16'h0001, 16'h0400, 16'h0000, 4'b1011, 1'b0, 1'b0, "R8 no partner pause");
        // R7: unlisted mode code
        run_case(2, 1, 16'h0020, 3'd7, 16'h0, 16'h0, 16'h0, 4'b1000, 1'b1, 1'b0, "R7 unlisted code");
        // R5: completion bit clear leaves status empty
        run_case(1, 0, 16'hFFDF, 3'd6, 16'h1, 16'h400, 16'h400, 4'b0000, 1'b0, 1'b0, "R5 not complete");
        // R4: never link; last swap and fail coincide
        run_case(1000, 1, 16'h0028, 3'd6, 16'h1, 16'h400, 16'h400, 4'b0000, 1'b0, 1'b1, "R4 no link");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule